// File: doc/BRIEF.md
# Tailbiting Duobinary Recursive Parity Encoder

This block produces the parity stream for one frame of bit couples with a recursive systematic encoder of memory three. The encoder consumes two data bits per cycle. It needs no termination tail, because the trellis closes on itself: the state at the end of the frame equals the state at the start. The frame sits in an external buffer that the block reads through a simple port. The buffer has one cycle of read latency.

A frame is read twice. The first read runs the encoder from the zero state, and its parity is thrown away. Only its final state is kept. From that final state and the frame length, the block derives the circulation state. The second read starts from the circulation state and emits one W/Y parity couple per data couple. When the second read is complete, the block raises a one-cycle completion flag. At the same time it reports whether the encoder really returned to its starting state.

Top module: `dbcrsc_enc`

## Requirements
- R1: While reset is held, and after it is released until a frame is accepted, `rd_en`, `par_valid`, `done` and `wrap_err` are 0.
- R2: `len_sel` selects the frame length in couples. The codes 0 to 11 map to 48, 64, 212, 220, 228, 424, 432, 440, 752, 848, 856 and 864. A start with a code of 12 to 15 is ignored: no read and no completion follow.
- R3: Each accepted frame is read twice. Each read raises `rd_en` on consecutive cycles with `rd_addr` = 0, 1, ..., N-1. `rd_data` returns one cycle after the address, with A in bit 1 and B in bit 0.
- R4: The state is (s1,s2,s3). Let f = A^B^s1^s3. The next state is (f, s1^B, s2^B).
- R5: The parity of a couple is W = f^s3 and Y = f^s2^s3, computed from the state before that couple is applied.
- R6: The first read produces no `par_valid`. The second read produces exactly N `par_valid` cycles, one per couple, in address order.
- R7: The second read starts in the state Sc that satisfies (I + G^N)·Sc = S_N over GF(2). S_N is the state after the first read from zero. G is the zero-input state transition of R4. As a result, the encoder ends the second read in Sc.
- R8: `done` is a one-cycle pulse in the cycle after the last `par_valid`. `wrap_err` is valid with it and is 1 only if the final state differs from Sc.
- R9: A start while a frame is in progress is ignored. `len_sel` is taken only at an accepted start.
- R10: A start in the cycle that `done` is high is accepted as a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe for a frame |
| len_sel | input | 4 | Frame length code |
| rd_en | output | 1 | Buffer read request |
| rd_addr | output | 10 | Couple index to read |
| rd_data | input | 2 | Couple returned one cycle after the read: {A,B} |
| par_valid | output | 1 | Parity couple valid |
| par_w | output | 1 | W parity bit |
| par_y | output | 1 | Y parity bit |
| done | output | 1 | Frame completion pulse |
| wrap_err | output | 1 | Final state differed from the start state (valid with done) |

## Verification
Two events can fall in the same cycle. The completion pulse of one frame can coincide with the start strobe of the next. In that cycle the controller has just returned to idle, so the strobe must open a new frame rather than be lost.

The bench provokes this case by watching for `done` away from the clock edge. In that same cycle it raises `start` with a new length code and a new data pattern. It then judges the second frame in the same way as any isolated frame: its read-address sequence, its N parity couples against a model that finds the circulation state by exhaustive search, and its own single completion pulse with `wrap_err` low.

// File: rtl/dbcrsc_pkg.sv
package dbcrsc_pkg;

  localparam int ADDR_W = 10;
  localparam int LSEL_W = 4;
  localparam int ST_W   = 3;
  localparam int NLEN   = 12;
  localparam int TRELLIS_ORDER = (1 << ST_W) - 1;

  typedef logic [ST_W-1:0]   st_t;
  typedef logic [ADDR_W-1:0] cnt_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RUN1, PH_DRAIN1, PH_CIRC, PH_RUN2, PH_DRAIN2, PH_FIN
  } phase_t;

  function automatic logic sel_ok(input logic [LSEL_W-1:0] sel);
    return (32'(sel) < NLEN);
  endfunction

  function automatic cnt_t sel_to_len(input logic [LSEL_W-1:0] sel);
    cnt_t n;
    case (sel)
      4'd0:    n = 10'd48;
      4'd1:    n = 10'd64;
      4'd2:    n = 10'd212;
      4'd3:    n = 10'd220;
      4'd4:    n = 10'd228;
      4'd5:    n = 10'd424;
      4'd6:    n = 10'd432;
      4'd7:    n = 10'd440;
      4'd8:    n = 10'd752;
      4'd9:    n = 10'd848;
      4'd10:   n = 10'd856;
      4'd11:   n = 10'd864;
      default: n = '0;
    endcase
    return n;
  endfunction

  // feedback node: both data bits plus first and last stage
  function automatic logic fb_bit(input st_t s, input logic a, input logic b);
    return a ^ b ^ s[2] ^ s[0];
  endfunction

  function automatic st_t step(input st_t s, input logic a, input logic b);
    logic f;
    f = fb_bit(s, a, b);
    return {f, s[2] ^ b, s[1] ^ b};
  endfunction

  function automatic logic par_w_of(input st_t s, input logic a, input logic b);
    return fb_bit(s, a, b) ^ s[0];
  endfunction

  function automatic logic par_y_of(input st_t s, input logic a, input logic b);
    return fb_bit(s, a, b) ^ s[1] ^ s[0];
  endfunction

  // G^p applied to s, with p below the trellis order
  function automatic st_t g_pow(input st_t s, input logic [2:0] p);
    st_t r;
    r = s;
    for (int i = 0; i < TRELLIS_ORDER; i++) begin
      if (i < 32'(p)) r = step(r, 1'b0, 1'b0);
    end
    return r;
  endfunction

  function automatic logic [2:0] len_mod(input cnt_t n);
    return 3'(n % cnt_t'(TRELLIS_ORDER));
  endfunction

  // solve (I + G^p) x = sn by search over the 8 states
  function automatic st_t circ_solve(input st_t sn, input logic [2:0] p);
    st_t r;
    r = '0;
    for (int c = 0; c < (1 << ST_W); c++) begin
      if ((st_t'(c) ^ g_pow(st_t'(c), p)) == sn) r = st_t'(c);
    end
    return r;
  endfunction

endpackage

// File: rtl/dbcrsc_ctrl.sv
module dbcrsc_ctrl
  import dbcrsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LSEL_W-1:0] len_sel,
  output logic              rd_en,
  output cnt_t              rd_addr,
  output cnt_t              len_q,
  output logic              accept,
  output logic              busy,
  output logic              dvld_q,
  output logic              pass2_q,
  output logic              load_circ,
  output logic              fin
);

  phase_t ph, ph_nx;
  cnt_t   cnt;
  logic   last_addr;
  logic   run_now;

  assign accept    = (ph == PH_IDLE) && start && sel_ok(len_sel);
  assign busy      = (ph != PH_IDLE);
  assign run_now   = (ph == PH_RUN1) || (ph == PH_RUN2);
  assign last_addr = (cnt == len_q - cnt_t'(1));
  assign load_circ = (ph == PH_CIRC);
  assign fin       = (ph == PH_FIN);
  assign rd_en     = run_now;
  assign rd_addr   = run_now ? cnt : '0;

  always_comb begin
    ph_nx = ph;
    case (ph)
      PH_IDLE:   if (accept) ph_nx = PH_RUN1;
      PH_RUN1:   if (last_addr) ph_nx = PH_DRAIN1;
      PH_DRAIN1: ph_nx = PH_CIRC;
      PH_CIRC:   ph_nx = PH_RUN2;
      PH_RUN2:   if (last_addr) ph_nx = PH_DRAIN2;
      PH_DRAIN2: ph_nx = PH_FIN;
      PH_FIN:    ph_nx = PH_IDLE;
      default:   ph_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      cnt     <= '0;
      len_q   <= '0;
      dvld_q  <= 1'b0;
      pass2_q <= 1'b0;
    end else begin
      ph      <= ph_nx;
      dvld_q  <= run_now;
      pass2_q <= (ph == PH_RUN2);
      if (accept) len_q <= sel_to_len(len_sel);
      if (accept || load_circ) cnt <= '0;
      else if (run_now && !last_addr) cnt <= cnt + cnt_t'(1);
    end
  end

endmodule

// File: rtl/dbcrsc_core.sv
module dbcrsc_core
  import dbcrsc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic load,
  input  st_t  load_val,
  input  logic step_en,
  input  logic a,
  input  logic b,
  output st_t  st,
  output logic w,
  output logic y
);

  assign w = par_w_of(st, a, b);
  assign y = par_y_of(st, a, b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       st <= '0;
    else if (clr)     st <= '0;
    else if (load)    st <= load_val;
    else if (step_en) st <= step(st, a, b);
  end

endmodule

// File: rtl/dbcrsc_circ.sv
module dbcrsc_circ
  import dbcrsc_pkg::*;
(
  input  st_t  s_end,
  input  cnt_t n,
  output st_t  s_circ
);

  logic [2:0] p;
  assign p      = len_mod(n);
  assign s_circ = circ_solve(s_end, p);

endmodule

// File: rtl/dbcrsc_enc.sv
module dbcrsc_enc
  import dbcrsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LSEL_W-1:0] len_sel,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [1:0]        rd_data,
  output logic              par_valid,
  output logic              par_w,
  output logic              par_y,
  output logic              done,
  output logic              wrap_err
);

  cnt_t len_q_w;
  logic accept_w, busy_w, dvld_w, pass2_w, load_circ_w, fin_w;
  st_t  core_st, sc_w, circ_q;
  logic w_w, y_w;

  dbcrsc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .len_sel(len_sel),
    .rd_en(rd_en), .rd_addr(rd_addr), .len_q(len_q_w),
    .accept(accept_w), .busy(busy_w), .dvld_q(dvld_w),
    .pass2_q(pass2_w), .load_circ(load_circ_w), .fin(fin_w)
  );

  dbcrsc_core u_core (
    .clk(clk), .rst_n(rst_n), .clr(accept_w), .load(load_circ_w),
    .load_val(sc_w), .step_en(dvld_w), .a(rd_data[1]), .b(rd_data[0]),
    .st(core_st), .w(w_w), .y(y_w)
  );

  dbcrsc_circ u_circ (
    .s_end(core_st), .n(len_q_w), .s_circ(sc_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_valid <= 1'b0;
      par_w     <= 1'b0;
      par_y     <= 1'b0;
      done      <= 1'b0;
      wrap_err  <= 1'b0;
      circ_q    <= '0;
    end else begin
      par_valid <= dvld_w && pass2_w;
      par_w     <= (dvld_w && pass2_w) ? w_w : 1'b0;
      par_y     <= (dvld_w && pass2_w) ? y_w : 1'b0;
      done      <= fin_w;
      wrap_err  <= fin_w && (core_st != circ_q);
      if (load_circ_w) circ_q <= sc_w;
    end
  end

endmodule

// File: rtl/dbcrsc_enc_chk.sv
module dbcrsc_enc_chk
  import dbcrsc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              par_valid,
  input logic              done,
  input logic              wrap_err,
  input logic              busy,
  input logic              load_circ,
  input st_t               core_st,
  input st_t               sc,
  input cnt_t              len_q
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !$past(busy) |-> !rd_en && !par_valid);

  // R3
  addr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_en) |-> rd_addr == '0);

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && $past(rd_en) |-> rd_addr == $past(rd_addr) + 1'b1);

  // R6
  par_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_valid |-> busy);

  // R7
  circ_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_circ |=> core_st == $past(sc));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R8
  wrap_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wrap_err);

  // R9
  len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(len_q));

endmodule

bind dbcrsc_enc dbcrsc_enc_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .rd_en(rd_en), .rd_addr(rd_addr),
  .par_valid(par_valid), .done(done), .wrap_err(wrap_err), .busy(busy_w),
  .load_circ(load_circ_w), .core_st(core_st), .sc(sc_w), .len_q(len_q_w)
);

// File: tb/dbcrsc_enc_tb_top.sv
module dbcrsc_enc_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] len_sel = '0;
  logic       rd_en;
  logic [9:0] rd_addr;
  logic [1:0] rd_data = '0;
  logic       par_valid, par_w, par_y, done, wrap_err;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int cur_seed = 0;

  always #4 clk = ~clk;

  dbcrsc_enc dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .len_sel(len_sel),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .par_valid(par_valid), .par_w(par_w), .par_y(par_y),
    .done(done), .wrap_err(wrap_err)
  );

  // {mode[1:0], code[3:0], N[9:0], seed[7:0]}; mode 1 = stray start mid-frame, 2 = chain next at done
  localparam logic [23:0] VEC [12] = '{
    {2'd0, 4'd0,  10'd48,  8'h13}, {2'd0, 4'd1,  10'd64,  8'h2a},
    {2'd0, 4'd2,  10'd212, 8'h07}, {2'd1, 4'd3,  10'd220, 8'h55},
    {2'd0, 4'd4,  10'd228, 8'h91}, {2'd0, 4'd5,  10'd424, 8'h3c},
    {2'd2, 4'd6,  10'd432, 8'hc4}, {2'd0, 4'd7,  10'd440, 8'h6e},
    {2'd0, 4'd8,  10'd752, 8'h21}, {2'd1, 4'd9,  10'd848, 8'hb7},
    {2'd0, 4'd10, 10'd856, 8'h48}, {2'd0, 4'd11, 10'd864, 8'hfd}
  };

  function automatic logic [1:0] pat(input int seed, input int k);
    int v;
    v = (k * 37 + seed * 11) ^ (k >> 2) ^ (seed * k) ^ (k >> 5);
    return {v[1] ^ v[4], v[0] ^ v[3]};
  endfunction

  // R4 next state; R5 parity {W,Y}
  function automatic logic [2:0] m_next(input logic [2:0] s, input logic [1:0] d);
    logic t;
    t = d[1] ^ d[0] ^ s[2] ^ s[0];
    return {t, s[2] ^ d[0], s[1] ^ d[0]};
  endfunction

  function automatic logic [1:0] m_par(input logic [2:0] s, input logic [1:0] d);
    logic t;
    t = d[1] ^ d[0] ^ s[2] ^ s[0];
    return {t ^ s[0], t ^ s[1] ^ s[0]};
  endfunction

  always @(posedge clk) rd_data <= pat(cur_seed, int'(rd_addr));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input int code, input int n, input int seed, input int mode,
                           input bit prestarted, input int nx_code, input int nx_seed);
    logic [1:0] exp_par [864];
    logic [2:0] s, sc;
    int found, nvalid, npar_bad, nrd, nrd_bad, ndone, werr, t, first_bad;
    found = 0;
    sc = '0;
    for (int c = 0; c < 8; c++) begin
      s = 3'(c);
      for (int k = 0; k < n; k++) s = m_next(s, pat(seed, k));
      if (s == 3'(c)) begin
        found = found + 1;
        sc = 3'(c);
      end
    end
    s = sc;
    for (int k = 0; k < n; k++) begin
      exp_par[k] = m_par(s, pat(seed, k));
      s = m_next(s, pat(seed, k));
    end
    if (!prestarted) begin
      cur_seed = seed;
      len_sel = 4'(code);
      start = 1'b1;
    end
    @(negedge clk);
    start = 1'b0;
    nvalid = 0; npar_bad = 0; nrd = 0; nrd_bad = 0; ndone = 0; werr = 0; t = 0;
    first_bad = -1;
    while (ndone == 0 && t < 4000) begin
      if (rd_en) begin
        if (int'(rd_addr) != (nrd % n)) nrd_bad = nrd_bad + 1;
        nrd = nrd + 1;
      end
      if (par_valid) begin
        if (nvalid < n && {par_w, par_y} != exp_par[nvalid]) begin
          npar_bad = npar_bad + 1;
          if (first_bad < 0) first_bad = nvalid;
        end
        nvalid = nvalid + 1;
      end
      if (mode == 1 && t == 60) begin
        len_sel = 4'd0;
        start = 1'b1;
      end else if (mode == 1 && t == 61) begin
        start = 1'b0;
      end
      if (done) begin
        ndone = 1;
        werr = int'(wrap_err);
        if (mode == 2) begin
          cur_seed = nx_seed;
          len_sel = 4'(nx_code);
          start = 1'b1;
        end
      end else begin
        @(negedge clk);
        t = t + 1;
      end
    end
    check(found == 1, "R7", "unique circulation state in model", found, 1);
    check(nrd == 2 * n && nrd_bad == 0, "R3", "read count / address order", nrd, 2 * n);
    check(nvalid == n, "R6", "parity couple count", nvalid, n);
    check(npar_bad == 0, "R4/R5/R7", "parity couples wrong (first index)", first_bad, -1);
    check(ndone == 1, "R8", "done pulse seen", ndone, 1);
    check(werr == 0, "R8", "wrap_err at done", werr, 0);
    if (mode == 1) check(nvalid == n, "R9", "stray start changed frame length", nvalid, n);
  endtask

  initial begin
    bit chained;
    int quiet;
    chained = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(!rd_en && !par_valid && !done && !wrap_err, "R1", "outputs in reset",
          int'({rd_en, par_valid, done, wrap_err}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!rd_en && !par_valid && !done && !wrap_err, "R1", "outputs after reset",
          int'({rd_en, par_valid, done, wrap_err}), 0);

    // R2 unsupported length code is ignored
    len_sel = 4'd13;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    quiet = 0;
    for (int i = 0; i < 40; i++) begin
      if (rd_en || done || par_valid) quiet = quiet + 1;
      @(negedge clk);
    end
    check(quiet == 0, "R2", "activity after code 13", quiet, 0);

    for (int i = 0; i < 12; i++) begin
      int mode, code, n, seed, nxc, nxs;
      mode = int'(VEC[i][23:22]);
      code = int'(VEC[i][21:18]);
      n    = int'(VEC[i][17:8]);
      seed = int'(VEC[i][7:0]);
      nxc  = (i < 11) ? int'(VEC[i+1][21:18]) : 0;
      nxs  = (i < 11) ? int'(VEC[i+1][7:0]) : 0;
      // R2 length mapping is confirmed by the N column through the R6 count
      run_frame(code, n, seed, mode, chained, nxc, nxs);
      if (chained) check(1'b1, "R10", "chained start accepted in done cycle", 1, 1);
      chained = (mode == 2);
    end

    // R9 no second completion after a frame with a stray start
    quiet = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (done || rd_en) quiet = quiet + 1;
    end
    check(quiet == 0, "R9", "spurious activity after last frame", quiet, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule